// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This block sits on the host side of a byte-wide, command-driven flash device and carries out a complete chip-erase pass without software help. It talks to the device over a plain parallel bus: an address, a write-data byte, a read-data byte, a write strobe and a read strobe. Every bus access holds its strobe high for a fixed number of clocks and is followed by one idle clock, so the device sees a fixed and predictable handshake.

A one-cycle start pulse begins the pass, which has three phases. First, every byte is programmed to 00h, one program command per byte. Second, the block sends the erase command twice and then lets the device work for a set number of idle clocks. Third, it checks each byte in turn: it writes the erase-verify command with the byte's address, then reads that byte back. A byte that does not read FFh triggers another erase of the whole chip. Checking then resumes at the failing byte, not at address zero. Every erase is counted. When the retry limit is reached, the pass stops with a failure. Each pass ends with a reset command to the device, and then a done or fail flag is raised. That flag stays up until the next start.

Top module: `flash_wipe_ctrl`

## Requirements
- R1: After reset both strobes are low, done and fail are low, and the erase count is zero.
- R2: A start pulse first programs addresses 0 to DEPTH-1 in ascending order. Each byte gets a write of 40h followed by a write of 00h at that address, and no erase command is sent before the last byte is programmed.
- R3: Every erase is two back-to-back writes of 20h. The erase count output goes up by one for each such pair, and it matches the number of erases the device saw.
- R4: After the second 20h write, the bus stays idle for exactly ERASE_WAIT+1 clocks before the next access.
- R5: A byte check is a write of A0h with the byte's address, followed by a read at that same address. A read of FFh passes the byte, and after a successful pass every byte of the device holds FFh.
- R6: When a read is not FFh, the chip is erased again and checking resumes at that same address. Addresses already passed are never checked again, so the number of checks is DEPTH plus the number of failed reads.
- R7: If a read fails and the erase count already equals MAX_TRIES, the block stops checking, raises fail rather than done, and never erases more than MAX_TRIES times.
- R8: Each pass ends with exactly one write of FFh. After it, exactly one of done or fail is raised, and that flag and the erase count hold their values until the next start.
- R9: Each access holds its strobe high for exactly BUS_CYC clocks, with the address stable the whole time. The two strobes are never high together, and consecutive accesses are separated by exactly one idle clock, except after the erase wait.
- R10: A start pulse while a pass is running has no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a pass when the block is idle |
| memAddr | output | ADDR_W | Byte address to the flash device |
| memWdata | output | 8 | Command or data byte written to the device |
| memRdata | input | 8 | Byte returned by the device during a read |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| done | output | 1 | Pass completed with every byte erased |
| fail | output | 1 | Pass stopped at the retry limit |
| eraseCount | output | TRY_W | Number of erases issued in the current or last pass |

## Verification
The bench contains a behavioural model of the flash device in which each address needs a chosen number of erases before it reads FFh. A clean array, where every byte erases on the first try, exercises the basic program-erase-verify flow. Next, one slow byte is swept across every address, and this tells a correct resume at the failing address apart from a restart at zero or an off-by-one address. Runs with two slow bytes needing different erase counts show that the count accumulates across failures. A byte that needs more erases than the limit checks the failure path and its stopping point. A stray start pulse during a run must leave every count unchanged.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

  typedef enum logic [7:0] {
    CODE_ZERO   = 8'h00,
    CODE_ERASE  = 8'h20,
    CODE_PROG   = 8'h40,
    CODE_VERIFY = 8'hA0,
    CODE_RESET  = 8'hFF
  } busCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     startWr;
    logic     startRd;
    busCode_e code;
    logic     addrClr;
    logic     addrInc;
    logic     waitLoad;
    logic     triesClr;
    logic     triesInc;
  } wipeCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic busDone;
    logic waitDone;
    logic lastAddr;
    logic byteOk;
    logic triesMax;
  } wipeSts_t;

endpackage

// File: rtl/wipe_datapath.sv
module wipe_datapath
  import wipe_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 3,
  parameter int ERASE_WAIT = 20,
  parameter int MAX_TRIES  = 3,
  parameter int TRY_W      = 2,
  parameter int BUS_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  wipeCtl_t          ctl,
  output wipeSts_t          sts,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              memWe,
  output logic              memRe,
  output logic [TRY_W-1:0]  triesCnt
);

  localparam int WAIT_W = $clog2(ERASE_WAIT + 1);
  localparam int BC_W   = $clog2(BUS_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_GAP} phase_e;

  phase_e            phase;
  logic [BC_W-1:0]   busCnt;
  logic [7:0]        rdReg;
  logic [ADDR_W-1:0] addrCnt;
  logic [WAIT_W-1:0] waitCnt;

  // bus access engine: BUS_CYC strobe clocks, then one idle clock
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      memWe    <= 1'b0;
      memRe    <= 1'b0;
      memWdata <= 8'h00;
      busCnt   <= '0;
      rdReg    <= 8'h00;
    end else begin
      case (phase)
        PH_ACT: begin
          if (busCnt == BC_W'(BUS_CYC - 1)) begin
            memWe <= 1'b0;
            memRe <= 1'b0;
            phase <= PH_GAP;
            if (memRe) rdReg <= memRdata;
          end else begin
            busCnt <= busCnt + BC_W'(1);
          end
        end
        default: begin
          if (ctl.startWr) begin
            memWe    <= 1'b1;
            memWdata <= ctl.code;
            busCnt   <= '0;
            phase    <= PH_ACT;
          end else if (ctl.startRd) begin
            memRe  <= 1'b1;
            busCnt <= '0;
            phase  <= PH_ACT;
          end else begin
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  // address, wait and retry counters
  always_ff @(posedge clk) begin
    if (rst) begin
      addrCnt  <= '0;
      waitCnt  <= '0;
      triesCnt <= '0;
    end else begin
      if (ctl.addrClr)      addrCnt <= '0;
      else if (ctl.addrInc) addrCnt <= addrCnt + ADDR_W'(1);

      if (ctl.waitLoad)      waitCnt <= WAIT_W'(ERASE_WAIT - 1);
      else if (waitCnt != 0) waitCnt <= waitCnt - WAIT_W'(1);

      if (ctl.triesClr)      triesCnt <= '0;
      else if (ctl.triesInc) triesCnt <= triesCnt + TRY_W'(1);
    end
  end

  assign memAddr      = addrCnt;
  assign sts.busDone  = (phase == PH_GAP);
  assign sts.waitDone = (waitCnt == '0);
  assign sts.lastAddr = (addrCnt == ADDR_W'(DEPTH - 1));
  assign sts.byteOk   = (rdReg == 8'hFF);
  assign sts.triesMax = (triesCnt == TRY_W'(MAX_TRIES));

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(memWe && memRe)); // R9
  AST_STROBE_END: assert property (@(posedge clk) disable iff (rst)
    ((memWe || memRe) && busCnt == BC_W'(BUS_CYC - 1)) |=> !(memWe || memRe)); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (memWe || memRe) |=> (!(memWe || memRe) || $stable(memAddr))); // R9
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (waitCnt != '0) |-> (!memWe && !memRe)); // R4
  AST_TRIES_CAP: assert property (@(posedge clk) disable iff (rst)
    triesCnt <= TRY_W'(MAX_TRIES)); // R7

endmodule

// File: rtl/wipe_control.sv
module wipe_control
  import wipe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  wipeSts_t sts,
  output wipeCtl_t ctl,
  output logic     done,
  output logic     fail
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PG_CMD, ST_PG_DATA, ST_ER_SETUP, ST_ER_GO,
    ST_ER_WAIT, ST_VF_CMD, ST_VF_READ, ST_END_CMD
  } state_e;

  state_e state, nextState;
  logic   failPend, setPass, setFail, accept;

  always_comb begin
    ctl       = '0;
    nextState = state;
    setPass   = 1'b0;
    setFail   = 1'b0;
    accept    = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        accept       = 1'b1;
        ctl.addrClr  = 1'b1;
        ctl.triesClr = 1'b1;
        ctl.startWr  = 1'b1;
        ctl.code     = CODE_PROG;
        nextState    = ST_PG_CMD;
      end
      ST_PG_CMD: if (sts.busDone) begin
        ctl.startWr = 1'b1;
        ctl.code    = CODE_ZERO;
        nextState   = ST_PG_DATA;
      end
      ST_PG_DATA: if (sts.busDone) begin
        ctl.startWr = 1'b1;
        if (sts.lastAddr) begin
          ctl.addrClr = 1'b1;
          ctl.code    = CODE_ERASE;
          nextState   = ST_ER_SETUP;
        end else begin
          ctl.addrInc = 1'b1;
          ctl.code    = CODE_PROG;
          nextState   = ST_PG_CMD;
        end
      end
      ST_ER_SETUP: if (sts.busDone) begin
        ctl.startWr  = 1'b1;
        ctl.code     = CODE_ERASE;
        ctl.triesInc = 1'b1;
        nextState    = ST_ER_GO;
      end
      ST_ER_GO: if (sts.busDone) begin
        ctl.waitLoad = 1'b1;
        nextState    = ST_ER_WAIT;
      end
      ST_ER_WAIT: if (sts.waitDone) begin
        ctl.startWr = 1'b1;
        ctl.code    = CODE_VERIFY;
        nextState   = ST_VF_CMD;
      end
      ST_VF_CMD: if (sts.busDone) begin
        ctl.startRd = 1'b1;
        nextState   = ST_VF_READ;
      end
      ST_VF_READ: if (sts.busDone) begin
        ctl.startWr = 1'b1;
        if (sts.byteOk && sts.lastAddr) begin
          ctl.code  = CODE_RESET;
          setPass   = 1'b1;
          nextState = ST_END_CMD;
        end else if (sts.byteOk) begin
          ctl.addrInc = 1'b1;
          ctl.code    = CODE_VERIFY;
          nextState   = ST_VF_CMD;
        end else if (sts.triesMax) begin
          ctl.code  = CODE_RESET;
          setFail   = 1'b1;
          nextState = ST_END_CMD;
        end else begin
          ctl.code  = CODE_ERASE;
          nextState = ST_ER_SETUP;
        end
      end
      ST_END_CMD: if (sts.busDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      failPend <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      state <= nextState;
      if (setPass)      failPend <= 1'b0;
      else if (setFail) failPend <= 1'b1;
      if (accept) begin
        done <= 1'b0;
        fail <= 1'b0;
      end else if (state == ST_END_CMD && sts.busDone) begin
        done <= !failPend;
        fail <= failPend;
      end
    end
  end

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((done || fail) && !start) |=> ($stable(done) && $stable(fail))); // R8
  AST_QUIET_RUN: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (!done && !fail)); // R10

endmodule

// File: rtl/flash_wipe_ctrl.sv
module flash_wipe_ctrl
  import wipe_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ERASE_WAIT = 20,
  parameter int MAX_TRIES  = 3,
  parameter int BUS_CYC    = 2,
  localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              memWe,
  output logic              memRe,
  output logic              done,
  output logic              fail,
  output logic [TRY_W-1:0]  eraseCount
);

  wipeCtl_t ctl;
  wipeSts_t sts;

  wipe_control u_control (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sts   (sts),
    .ctl   (ctl),
    .done  (done),
    .fail  (fail)
  );

  wipe_datapath #(
    .DEPTH      (DEPTH),
    .ADDR_W     (ADDR_W),
    .ERASE_WAIT (ERASE_WAIT),
    .MAX_TRIES  (MAX_TRIES),
    .TRY_W      (TRY_W),
    .BUS_CYC    (BUS_CYC)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .sts      (sts),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .triesCnt (eraseCount)
  );

endmodule

// File: tb/flash_wipe_ctrl_test.sv
module flash_wipe_ctrl_test;

  localparam int DEPTH = 8;
  localparam int WAITC = 20;
  localparam int MAXT  = 3;
  localparam int BC    = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int TW    = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic memWe, memRe, done, fail;
  logic [TW-1:0] eraseCount;

  always #4 clk = ~clk;

  flash_wipe_ctrl #(.DEPTH(DEPTH), .ERASE_WAIT(WAITC), .MAX_TRIES(MAXT), .BUS_CYC(BC)) uut (
    .clk(clk), .rst(rst), .start(start), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .memRe(memRe), .done(done), .fail(fail),
    .eraseCount(eraseCount));

  int total = 0;
  int failN = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failN++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  logic [7:0] devMem [DEPTH];
  int need [DEPTH];
  assign memRdata = devMem[memAddr];

  logic prevWe = 1'b0, prevRe = 1'b0;
  logic [AW-1:0] wA;
  logic [7:0] wD;
  bit expectData, armed, firstAcc, longNext, erasedOnce;
  int devErases, progCnt, progOrderErr, preErr, vfyCnt, vfyOrderErr, lastV, vAddr;
  int readCnt, readErr, lowCnt, hiCnt, gapErr, waitErr, lenErr, resetCnt, lastCmd, bothErr;

  task automatic devReset();
    expectData = 0; armed = 0; firstAcc = 1; longNext = 0; erasedOnce = 0;
    devErases = 0; progCnt = 0; progOrderErr = 0; preErr = 0; vfyCnt = 0;
    vfyOrderErr = 0; lastV = -1; vAddr = -1; readCnt = 0; readErr = 0;
    gapErr = 0; waitErr = 0; lenErr = 0; resetCnt = 0; lastCmd = -1; bothErr = 0;
    lowCnt = 0; hiCnt = 0;
    for (int a = 0; a < DEPTH; a++) devMem[a] = 8'h5A;
  endtask

  task automatic devWrite(input int a, input logic [7:0] d);
    if (expectData) begin
      expectData = 0;
      if (a != progCnt || d != 8'h00 || erasedOnce) progOrderErr++;
      devMem[a] = d;
      progCnt++;
    end else begin
      lastCmd = d;
      if (d == 8'h20 && armed) begin
        armed = 0;
        if (!erasedOnce) begin
          for (int k = 0; k < DEPTH; k++) if (devMem[k] != 8'h00) preErr++;
        end
        erasedOnce = 1;
        devErases++;
        longNext = 1;
        for (int k = 0; k < DEPTH; k++) if (need[k] <= devErases) devMem[k] = 8'hFF;
      end else begin
        armed = (d == 8'h20);
        if (d == 8'h40) expectData = 1;
        if (d == 8'hA0) begin
          if (a < lastV) vfyOrderErr++;
          lastV = a; vAddr = a; vfyCnt++;
        end
        if (d == 8'hFF) resetCnt++;
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (memWe && memRe) bothErr++;
      if (memWe) begin wA = memAddr; wD = memWdata; end
      if ((memWe || memRe) && !(prevWe || prevRe)) begin
        if (!firstAcc) begin
          if (longNext) begin if (lowCnt != WAITC + 1) waitErr++; end
          else if (lowCnt != 1) gapErr++;
        end
        firstAcc = 0; longNext = 0; lowCnt = 0; hiCnt = 0;
        if (memRe) begin
          readCnt++;
          if (int'(memAddr) != vAddr) readErr++;
        end
      end
      if (memWe || memRe) hiCnt++; else lowCnt++;
      if ((prevWe || prevRe) && !(memWe || memRe) && hiCnt != BC) lenErr++;
      if (prevWe && !memWe) devWrite(int'(wA), wD);
      prevWe = memWe; prevRe = memRe;
    end
  end

  // expected outcome derived from the requirements
  task automatic expect_run(output int expE, output int expV, output bit expFail);
    int e = 1;
    expV = 0; expFail = 0;
    for (int a = 0; a < DEPTH && !expFail; a++) begin
      while (need[a] > e && !expFail) begin
        expV++;
        if (e == MAXT) expFail = 1; else e++;
      end
      if (!expFail) expV++;
    end
    expE = e;
  endtask

  task automatic run(input string name, input int strayAt);
    int expE, expV, cyc, allFF;
    bit expFail, hung;
    devReset();
    expect_run(expE, expV, expFail);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0; hung = 0;
    while (!(done || fail)) begin
      @(negedge clk);
      cyc++;
      start = (cyc == strayAt);
      if (cyc > 5000) begin hung = 1; break; end
    end
    start = 1'b0;
    chk(!hung, "R8", {name, " finished before watchdog"}, cyc, 5000);
    repeat (6) @(negedge clk);
    chk(done == !expFail, "R8", {name, " done"}, done, !expFail);
    chk(fail == expFail, "R7", {name, " fail"}, fail, expFail);
    chk(int'(eraseCount) == expE, "R3", {name, " eraseCount"}, eraseCount, expE);
    chk(devErases == expE, "R3", {name, " erases seen by device"}, devErases, expE);
    chk(progCnt == DEPTH && progOrderErr == 0 && preErr == 0, "R2",
        {name, " pre-program"}, progCnt * 100 + progOrderErr + preErr, DEPTH * 100);
    chk(vfyCnt == expV && vfyOrderErr == 0, "R6", {name, " verify count/order"},
        vfyCnt + 100 * vfyOrderErr, expV);
    chk(readCnt == vfyCnt && readErr == 0, "R5", {name, " reads match verify"},
        readCnt + 100 * readErr, vfyCnt);
    chk(waitErr == 0, "R4", {name, " erase wait errors"}, waitErr, 0);
    chk(gapErr == 0 && lenErr == 0 && bothErr == 0, "R9", {name, " bus timing errors"},
        gapErr + lenErr + bothErr, 0);
    chk(resetCnt == 1 && lastCmd == 8'hFF, "R8", {name, " final reset command"}, lastCmd, 8'hFF);
    allFF = 1;
    for (int a = 0; a < DEPTH; a++) if (devMem[a] != 8'hFF) allFF = 0;
    if (!expFail) chk(allFF == 1, "R5", {name, " array erased"}, allFF, 1);
    if (strayAt > 0) chk(vfyCnt == expV && devErases == expE, "R10",
        {name, " stray start ignored"}, vfyCnt, expV);
  endtask

  bit finished = 0;

  initial begin
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    repeat (4) @(negedge clk);
    chk(!memWe && !memRe, "R1", "strobes in reset", memWe + memRe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fail, "R1", "flags after reset", done + fail, 0);
    chk(eraseCount == 0, "R1", "eraseCount after reset", eraseCount, 0);
    chk(!memWe && !memRe, "R1", "bus idle after reset", memWe + memRe, 0);

    run("clean", 0);
    for (int s = 0; s < DEPTH; s++) begin
      for (int a = 0; a < DEPTH; a++) need[a] = 1;
      need[s] = 2;
      run($sformatf("slow@%0d", s), 0);
    end
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[DEPTH-1] = 3;
    run("last-needs-3", 0);
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[2] = 2; need[5] = 3;
    run("two-slow", 0);
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[4] = MAXT + 1;
    run("over-limit", 0);
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[1] = 2;
    run("stray-start", 70);

    finished = 1;
    $display("%0d/%0d checks passed", total - failN, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; failN++;
      $display("FAIL R8 global watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - failN, total);
      $finish;
    end
  end

endmodule